// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Flags

This block holds a small bank of binary lock flags that two independent agents, a left port and a right port, use to agree on who currently owns a shared resource. Each port issues semaphore accesses through its own select, read/write, output-enable, address and data lines. A write whose data bit 0 is 0 asks for a flag's token, and a write whose bit 0 is 1 gives it back. A read tells that port whether it holds the token: 0 means "you own it" and 1 means "you do not".

Every flag keeps a separate request bit for each side. When one side already holds the token, a request from the other side is remembered rather than lost. The token passes to that side in the same cycle in which the holder releases it. If both sides ask for a free flag in the same cycle, a per-flag alternating tie bit picks the winner.

A read returns the flag bit copied onto every data bit. The value is captured at the start of a read access and kept until the access ends, so a write from the other side never changes a read that is in progress. A port that polls a flag must therefore end the access and start a new one to see a fresh value.

Top module: `dual_port_semaphore`

## Requirements
- R1: There are NUM_FLAGS (default 8) independent flags. A flag is chosen by the low $clog2(NUM_FLAGS) address bits (bits 2:0 by default), and the higher address bits have no effect.
- R2: A port writes a flag in a cycle where cs=1, sem_n=0 and rw=0. A port starts or continues a read access in a cycle where cs=1, sem_n=0, rw=1 and oe_n=0. No other combination changes any flag or request.
- R3: A write uses only data bit 0. The value 0 sets that side's request bit for the flag and the value 1 clears it. Data bits 15:1 are ignored.
- R4: When one side requests a free flag, that side reads 0 and the other side reads 1 from the cycle after the write.
- R5: While one side holds a flag, a 0 written by the other side changes neither side's read value. That request stays pending.
- R6: When the holder writes 1 and the other side has a pending request, the other side owns the flag from the next cycle and reads 0. With no pending request, both sides read 1.
- R7: A write of 1 from the side that does not hold the flag never releases it. It only withdraws that side's own pending request, so a later release by the holder leaves the flag free.
- R8: A read drives the flag value onto all DATA_W read-data bits: all ones or all zeros.
- R9: Read data is loaded on the clock edge that ends the first cycle of a read access, from the flag state before that edge, and is visible after that edge. It stays unchanged while the access continues, even if the address or the flags change. At all other times read data holds its last value.
- R10: When both sides request the same free flag in the same cycle, exactly one side receives the token. Each flag has its own tie bit, which favours the left side after reset and alternates after every tie on that flag.
- R11: A synchronous active-high reset makes every flag free with no pending requests, and sets both read-data buses to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cs | input | 1 | Left port enable, active high |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_rw | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address; the low bits pick the flag |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left read data, registered |
| r_cs | input | 1 | Right port enable, active high |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_rw | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address; the low bits pick the flag |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right read data, registered |

## Verification
The ownership logic is driven with single-side request and release pairs, requests from the locked-out side followed by a release from the holder, and withdrawals from the locked-out side. Together these separate an automatic hand-over from a plain release. Same-cycle requests on one flag are repeated to show that the tie bit alternates, and a second flag is used to show that each flag keeps its own tie bit. Writes with non-zero upper address bits, non-zero upper data bits or an inactive select show that those inputs are ignored. A read that is held open while its address changes, and a read attempted with output enable inactive, tell a frozen capture apart from a live read. A behavioural model compares both read buses on every clock.

// File: rtl/dsem_pkg.sv
package dsem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NUM_SIDES = 2;

  typedef struct packed {
    logic wr;    // write strobe this cycle
    logic wbit;  // data bit 0
    logic rd;    // read access active this cycle
  } port_cmd_t;

endpackage

// File: rtl/dsem_port_decode.sv
module dsem_port_decode
  import dsem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              cs,
  input  logic              sem_n,
  input  logic              rw,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output port_cmd_t         cmd,
  output logic [IDX_W-1:0]  idx
);

  logic sel;
  logic unused_hi;

  // Upper address bits and upper data bits carry no meaning (R1, R3)
  generate
    if (DATA_W > 1 && ADDR_W > IDX_W) begin : g_spare
      assign unused_hi = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
    end else if (DATA_W > 1) begin : g_spare_d
      assign unused_hi = ^wdata[DATA_W-1:1];
    end else if (ADDR_W > IDX_W) begin : g_spare_a
      assign unused_hi = ^addr[ADDR_W-1:IDX_W];
    end else begin : g_spare_none
      assign unused_hi = 1'b0;
    end
  endgenerate

  always_comb begin
    sel      = cs & ~sem_n;
    cmd.wr   = sel & ~rw;
    cmd.wbit = wdata[0];
    cmd.rd   = sel & rw & ~oe_n;
    idx      = addr[IDX_W-1:0];
  end

endmodule

// File: rtl/dsem_flag_cell.sv
module dsem_flag_cell
  import dsem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_wr,
  input  logic l_bit,
  input  logic r_wr,
  input  logic r_bit,
  output logic l_view,
  output logic r_view
);

  logic   req_l, req_r, tie_rr;
  logic   req_l_nx, req_r_nx, tie_rr_nx;
  owner_e owner, owner_nx;

  always_comb begin
    req_l_nx  = l_wr ? ~l_bit : req_l;
    req_r_nx  = r_wr ? ~r_bit : req_r;
    owner_nx  = owner;
    tie_rr_nx = tie_rr;
    case (owner)
      OWN_LEFT: begin
        if (!req_l_nx) owner_nx = req_r_nx ? OWN_RIGHT : OWN_NONE;
      end
      OWN_RIGHT: begin
        if (!req_r_nx) owner_nx = req_l_nx ? OWN_LEFT : OWN_NONE;
      end
      default: begin
        if (req_l_nx && req_r_nx) begin
          owner_nx  = tie_rr ? OWN_RIGHT : OWN_LEFT;
          tie_rr_nx = ~tie_rr;
        end else if (req_l_nx) begin
          owner_nx = OWN_LEFT;
        end else if (req_r_nx) begin
          owner_nx = OWN_RIGHT;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l  <= 1'b0;
      req_r  <= 1'b0;
      tie_rr <= 1'b0;
      owner  <= OWN_NONE;
    end else begin
      req_l  <= req_l_nx;
      req_r  <= req_r_nx;
      tie_rr <= tie_rr_nx;
      owner  <= owner_nx;
    end
  end

  // Active-low view: 0 only for the side that holds the token
  assign l_view = (owner != OWN_LEFT);
  assign r_view = (owner != OWN_RIGHT);

  AST_HOLDER_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    ((owner == OWN_LEFT) |-> req_l) and ((owner == OWN_RIGHT) |-> req_r)); // R5

  AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && l_wr && l_bit && req_r && !r_wr) |=> (owner == OWN_RIGHT)); // R6

  AST_NO_STEAL: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_RIGHT && !(r_wr && r_bit)) |=> (owner == OWN_RIGHT)); // R7

  AST_TIE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_NONE && l_wr && !l_bit && r_wr && !r_bit)
      |=> (owner != OWN_NONE && tie_rr != $past(tie_rr))); // R10

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!l_wr && !r_wr) |=> ($stable(req_l) && $stable(req_r))); // R2

endmodule

// File: rtl/dsem_read_latch.sv
module dsem_read_latch #(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = 3,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [IDX_W-1:0]     idx,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [DATA_W-1:0]    rdata
);

  logic rd_q;
  logic sel_bit;

  assign sel_bit = flags[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      rdata <= '1;
    end else begin
      rd_q <= rd;
      if (rd && !rd_q) rdata <= {DATA_W{sel_bit}};
    end
  end

  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rd && rd_q) |=> $stable(rdata)); // R9

endmodule

// File: rtl/dual_port_semaphore.sv
module dual_port_semaphore
  import dsem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_cs,
  input  logic              l_sem_n,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_cs,
  input  logic              r_sem_n,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

  logic                 cs_a    [NUM_SIDES];
  logic                 sem_n_a [NUM_SIDES];
  logic                 rw_a    [NUM_SIDES];
  logic                 oe_n_a  [NUM_SIDES];
  logic [ADDR_W-1:0]    addr_a  [NUM_SIDES];
  logic [DATA_W-1:0]    wdata_a [NUM_SIDES];
  logic [DATA_W-1:0]    rdata_a [NUM_SIDES];
  port_cmd_t            cmd_a   [NUM_SIDES];
  logic [IDX_W-1:0]     idx_a   [NUM_SIDES];
  logic [NUM_FLAGS-1:0] view_a  [NUM_SIDES];
  logic [NUM_FLAGS-1:0] l_view_v, r_view_v;

  assign cs_a[0] = l_cs;     assign cs_a[1] = r_cs;
  assign sem_n_a[0] = l_sem_n; assign sem_n_a[1] = r_sem_n;
  assign rw_a[0] = l_rw;     assign rw_a[1] = r_rw;
  assign oe_n_a[0] = l_oe_n; assign oe_n_a[1] = r_oe_n;
  assign addr_a[0] = l_addr; assign addr_a[1] = r_addr;
  assign wdata_a[0] = l_wdata; assign wdata_a[1] = r_wdata;
  assign view_a[0] = l_view_v; assign view_a[1] = r_view_v;
  assign l_rdata = rdata_a[0];
  assign r_rdata = rdata_a[1];

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      dsem_port_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
      ) u_dec (
        .cs(cs_a[s]), .sem_n(sem_n_a[s]), .rw(rw_a[s]), .oe_n(oe_n_a[s]),
        .addr(addr_a[s]), .wdata(wdata_a[s]),
        .cmd(cmd_a[s]), .idx(idx_a[s])
      );

      dsem_read_latch #(
        .NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)
      ) u_rd (
        .clk(clk), .rst(rst), .rd(cmd_a[s].rd), .idx(idx_a[s]),
        .flags(view_a[s]), .rdata(rdata_a[s])
      );
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      logic hit_l, hit_r;
      assign hit_l = cmd_a[0].wr && (idx_a[0] == IDX_W'(f));
      assign hit_r = cmd_a[1].wr && (idx_a[1] == IDX_W'(f));

      dsem_flag_cell u_cell (
        .clk(clk), .rst(rst),
        .l_wr(hit_l), .l_bit(cmd_a[0].wbit),
        .r_wr(hit_r), .r_bit(cmd_a[1].wbit),
        .l_view(l_view_v[f]), .r_view(r_view_v[f])
      );
    end
  endgenerate

  AST_RESET_FREE: assert property (@(posedge clk) $past(rst) |-> (l_rdata == '1 && r_rdata == '1)); // R11

endmodule

// File: tb/dual_port_semaphore_tb.sv
module dual_port_semaphore_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int AW = 13;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          d_cs    [2];
  logic          d_sem_n [2];
  logic          d_rw    [2];
  logic          d_oe_n  [2];
  logic [AW-1:0] d_addr  [2];
  logic [DW-1:0] d_wdata [2];
  logic [DW-1:0] q_rd    [2];

  int errors = 0;
  int checks = 0;
  bit started = 0;

  dual_port_semaphore #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .l_cs(d_cs[0]), .l_sem_n(d_sem_n[0]), .l_rw(d_rw[0]), .l_oe_n(d_oe_n[0]),
    .l_addr(d_addr[0]), .l_wdata(d_wdata[0]), .l_rdata(q_rd[0]),
    .r_cs(d_cs[1]), .r_sem_n(d_sem_n[1]), .r_rw(d_rw[1]), .r_oe_n(d_oe_n[1]),
    .r_addr(d_addr[1]), .r_wdata(d_wdata[1]), .r_rdata(q_rd[1])
  );

  // Behavioural reference: holder index per flag (-1 free), wish lists, tie toggles
  int          m_hold [NF];
  bit          m_want [2][NF];
  bit          m_tie  [NF];
  logic [DW-1:0] m_exp [2];
  bit          m_rdq  [2];

  always @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NF; f++) begin
        m_hold[f] = -1; m_want[0][f] = 0; m_want[1][f] = 0; m_tie[f] = 0;
      end
      m_exp[0] = '1; m_exp[1] = '1; m_rdq[0] = 0; m_rdq[1] = 0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        bit act;
        int fi;
        act = d_cs[s] && !d_sem_n[s] && d_rw[s] && !d_oe_n[s];
        fi = int'(d_addr[s] % NF);
        if (act && !m_rdq[s]) m_exp[s] = (m_hold[fi] == s) ? '0 : '1;
        m_rdq[s] = act;
      end
      for (int s = 0; s < 2; s++) begin
        if (d_cs[s] && !d_sem_n[s] && !d_rw[s])
          m_want[s][int'(d_addr[s] % NF)] = (d_wdata[s][0] == 1'b0);
      end
      for (int f = 0; f < NF; f++) begin
        if (m_hold[f] >= 0 && !m_want[m_hold[f]][f])
          m_hold[f] = m_want[1 - m_hold[f]][f] ? 1 - m_hold[f] : -1;
        else if (m_hold[f] < 0) begin
          if (m_want[0][f] && m_want[1][f]) begin
            m_hold[f] = m_tie[f] ? 1 : 0;
            m_tie[f] = !m_tie[f];
          end else if (m_want[0][f]) m_hold[f] = 0;
          else if (m_want[1][f]) m_hold[f] = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      for (int s = 0; s < 2; s++) begin
        checks++;
        if (q_rd[s] !== m_exp[s]) begin
          errors++;
          $display("FAIL R9 model side=%0d actual=%h expected=%h", s, q_rd[s], m_exp[s]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int s);
    d_cs[s] = 0; d_sem_n[s] = 1; d_rw[s] = 1; d_oe_n[s] = 1;
  endtask

  task automatic drive(input int s, input logic cs, input logic semn, input logic rw,
                       input logic oen, input logic [AW-1:0] a, input logic [DW-1:0] w);
    d_cs[s] = cs; d_sem_n[s] = semn; d_rw[s] = rw; d_oe_n[s] = oen;
    d_addr[s] = a; d_wdata[s] = w;
  endtask

  task automatic wr(input int s, input logic [AW-1:0] a, input logic [DW-1:0] w);
    @(negedge clk); drive(s, 1, 0, 0, 1, a, w);
    @(negedge clk); idle(s);
  endtask

  task automatic wr2(input logic [AW-1:0] al, input logic wl, input logic [AW-1:0] ar, input logic wr_b);
    @(negedge clk); drive(0, 1, 0, 0, 1, al, {15'd0, wl}); drive(1, 1, 0, 0, 1, ar, {15'd0, wr_b});
    @(negedge clk); idle(0); idle(1);
  endtask

  task automatic rd(input int s, input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); drive(s, 1, 0, 1, 0, a, '0);
    @(negedge clk); v = q_rd[s]; idle(s);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    for (int s = 0; s < 2; s++) begin
      d_addr[s] = '0; d_wdata[s] = '0; idle(s);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    @(negedge clk);
    chk("R11 reset left rdata", q_rd[0], 16'hFFFF);
    chk("R11 reset right rdata", q_rd[1], 16'hFFFF);
    rd(0, 13'd0, v); chk("R11 flag0 free left", v, 16'hFFFF);

    // R1 + R4: left requests flag0 through an address with high bits set
    wr(0, 13'h1A40, 16'h0000);
    rd(0, 13'd0, v); chk("R4 left owns flag0", v, 16'h0000);
    rd(1, 13'h0F00, v); chk("R1 right sees flag0 busy via high bits", v, 16'hFFFF);
    rd(1, 13'd1, v); chk("R1 other flag untouched", v, 16'hFFFF);

    // R5: right asks while left holds
    wr(1, 13'd0, 16'h0000);
    rd(0, 13'd0, v); chk("R5 left keeps flag0", v, 16'h0000);
    rd(1, 13'd0, v); chk("R5 right still locked", v, 16'hFFFF);

    // R6: release hands over, then free
    wr(0, 13'd0, 16'h0001);
    rd(1, 13'd0, v); chk("R6 handover to right", v, 16'h0000);
    rd(0, 13'd0, v); chk("R6 left lost flag0", v, 16'hFFFF);
    wr(1, 13'd0, 16'h0001);
    rd(1, 13'd0, v); chk("R6 free after release", v, 16'hFFFF);

    // R3: only data bit 0 counts
    wr(1, 13'd3, 16'hFFFE);
    rd(1, 13'd3, v); chk("R3 bit0=0 requests", v, 16'h0000);
    wr(1, 13'd3, 16'h0001);
    rd(1, 13'd3, v); chk("R3 bit0=1 releases", v, 16'hFFFF);

    // R7: non-holder write of 1 does not release; withdrawal is honoured
    wr(0, 13'd2, 16'h0000);
    wr(1, 13'd2, 16'h0001);
    rd(0, 13'd2, v); chk("R7 left still holds flag2", v, 16'h0000);
    wr(1, 13'd2, 16'h0000);
    wr(1, 13'd2, 16'h0001);
    wr(0, 13'd2, 16'h0001);
    rd(1, 13'd2, v); chk("R7 withdrawn request not granted", v, 16'hFFFF);

    // R2: gated writes have no effect
    @(negedge clk); drive(0, 0, 0, 0, 1, 13'd5, 16'h0000);
    @(negedge clk); drive(0, 1, 1, 0, 1, 13'd5, 16'h0000);
    @(negedge clk); idle(0);
    rd(0, 13'd5, v); chk("R2 gated write left view", v, 16'hFFFF);
    rd(1, 13'd5, v); chk("R2 gated write right view", v, 16'hFFFF);
    wr(1, 13'd5, 16'h0000);
    rd(0, 13'd5, v); chk("R2 flag5 taken after gated tries", v, 16'hFFFF);
    wr(1, 13'd5, 16'h0001);

    // R2: read without output enable keeps old data
    wr(0, 13'd6, 16'h0000);
    @(negedge clk); drive(0, 1, 0, 1, 1, 13'd6, '0);
    @(negedge clk); chk("R2 oe_n high no capture", q_rd[0], 16'hFFFF); idle(0);
    rd(0, 13'd6, v); chk("R8 all bits zero", v, 16'h0000);
    wr(0, 13'd6, 16'h0001);

    // R10: ties alternate per flag
    wr2(13'd4, 0, 13'd4, 0);
    rd(0, 13'd4, v); chk("R10 first tie left wins", v, 16'h0000);
    rd(1, 13'd4, v); chk("R10 first tie right loses", v, 16'hFFFF);
    wr2(13'd4, 1, 13'd4, 1);
    rd(1, 13'd4, v); chk("R10 both release free", v, 16'hFFFF);
    wr2(13'd4, 0, 13'd4, 0);
    rd(1, 13'd4, v); chk("R10 second tie right wins", v, 16'h0000);
    rd(0, 13'd4, v); chk("R10 second tie left loses", v, 16'hFFFF);
    wr2(13'd4, 1, 13'd4, 1);
    wr2(13'd7, 0, 13'd7, 0);
    rd(0, 13'd7, v); chk("R10 per-flag tie bit", v, 16'h0000);
    wr2(13'd7, 1, 13'd7, 1);

    // R9: held read stays frozen while address moves
    wr(0, 13'd1, 16'h0000);
    @(negedge clk); drive(0, 1, 0, 1, 0, 13'd1, '0);
    @(negedge clk); chk("R9 capture owned flag1", q_rd[0], 16'h0000); d_addr[0] = 13'd0;
    @(negedge clk); chk("R9 frozen after address change", q_rd[0], 16'h0000);
    @(negedge clk); chk("R9 still frozen", q_rd[0], 16'h0000); idle(0);
    rd(0, 13'd0, v); chk("R9 fresh access sees flag0", v, 16'hFFFF);
    wr(0, 13'd1, 16'h0001);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule